// File: doc/BRIEF.md
# USB Transmit Endpoint FIFO Controller

This block manages the transmit buffer of one USB IN endpoint. Firmware or a DMA engine pushes payload bytes through a byte write port. It then arms the endpoint with a one-cycle command that also latches the data PID to use. When the packet engine reports an IN token addressed to this endpoint, the controller answers one cycle later. The answer is a data packet, a NAK when the endpoint is not armed, or a STALL when the stall configuration is set.

During a data packet the engine pulls bytes one at a time. It ends the transaction with either an ACK or an error indication. An ACK releases the bytes, clears the arm bit and sets a done flag. An error rewinds the read position, so the same payload goes out again on the next IN token. The bytes stay counted as occupied until the ACK, so the writer can never overwrite data that may still be needed for a retry.

The controller also provides a free-space count, a low-level warning with a selectable threshold, a flush command and sticky event flags. A status-read strobe clears the event flags. Depth and data width are parameters, and the depth must be a power of two.

Top module: `tx_ep_fifo_ctrl`

## Requirements
- R1: After reset `free_cnt_o` equals DEPTH (64 by default) and each accepted write lowers it by one. `free_cnt_o` never exceeds DEPTH.
- R2: A write while `free_cnt_o` is 0 is dropped: the count stays 0 and `ovf_o` is set.
- R3: An IN token with `ep_en_i` high, the endpoint armed and `stall_i` low gives `resp_o` = 1 (data) in the next cycle. In that cycle `pid_o` holds the `toggle_i` value latched at arming and `len_o` holds the stored byte count. Each `rd_req_i` then presents the next byte on `rd_data_o` in write order.
- R4: An IN token with `ep_en_i` high while the endpoint is not armed and `stall_i` is low gives `resp_o` = 2 (NAK) and sets the sticky `nak_ev_o`.
- R5: An IN token with `ep_en_i` and `stall_i` high gives `resp_o` = 3 (STALL), whether or not the endpoint is armed. It clears `tx_en_o`, sets `done_o` and leaves the stored data untouched.
- R6: `ack_i` during a packet releases the sent bytes, so `free_cnt_o` rises by the packet length. It also clears `tx_en_o` and sets `done_o`.
- R7: `err_i` without `ack_i` during a packet keeps the data and `tx_en_o`. The next IN token resends the same bytes from the first one.
- R8: `flush_i` empties the FIFO (`free_cnt_o` = DEPTH) and aborts a packet in progress. It takes priority over writes and tokens in the same cycle.
- R9: `warn_o` follows the stored byte count n according to `warn_lim_i`: 0 means off, 1 means n<=4, 2 means n<=8, 3 means n<=16.
- R10: `stat_rd_i` clears `done_o`, `nak_ev_o` and `ovf_o`. A new event in the same cycle wins over the clear.
- R11: An IN token while `ep_en_i` is low gets no response (`resp_o` = 0) and does not set `nak_ev_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Byte write strobe |
| wr_data_i | input | DW | Byte to append |
| arm_i | input | 1 | Arm transmission, latch PID |
| toggle_i | input | 1 | PID to latch on arm (0 = DATA0, 1 = DATA1) |
| flush_i | input | 1 | Empty FIFO, abort packet |
| stall_i | input | 1 | Answer tokens with STALL |
| warn_lim_i | input | 2 | Warning threshold select |
| ep_en_i | input | 1 | Endpoint enabled |
| in_tok_i | input | 1 | IN token for this endpoint |
| rd_req_i | input | 1 | Engine consumes current byte |
| ack_i | input | 1 | Host acknowledged packet |
| err_i | input | 1 | Transaction failed |
| stat_rd_i | input | 1 | Status read, clears event flags |
| resp_o | output | 2 | 0 none, 1 data, 2 NAK, 3 STALL (one cycle) |
| pid_o | output | 1 | Data PID of the armed packet |
| len_o | output | CW | Packet length captured at the token |
| rd_data_o | output | DW | Current byte for the engine |
| tx_en_o | output | 1 | Endpoint armed |
| done_o | output | 1 | Packet or STALL completed |
| nak_ev_o | output | 1 | NAK event, sticky |
| ovf_o | output | 1 | Write to a full FIFO, sticky |
| free_cnt_o | output | CW | Empty byte slots |
| warn_o | output | 1 | Low-level warning |

## Verification
The checker watches several behaviours on every cycle. It checks that every token on an enabled, idle endpoint gets some answer and that STALL wins over data. It checks that an ACK always ends with done set and the endpoint disarmed, and that an error keeps both the arm state and the occupancy. It also checks that a flush empties the buffer, that a write to a full buffer is dropped, and that the warning is off when its limit is zero. Some behaviours only the bench scenarios can show. These are the byte order of a packet, replay of the identical payload from the first byte after an error, the exact warning thresholds, and the clearing of the flags by a status read.

// File: rtl/tx_ep_pkg.sv
package tx_ep_pkg;
  typedef enum logic [1:0] {
    RESP_NONE  = 2'd0,
    RESP_DATA  = 2'd1,
    RESP_NAK   = 2'd2,
    RESP_STALL = 2'd3
  } resp_e;

  function automatic int warn_thr(input logic [1:0] lim);
    case (lim)
      2'd1:    return 4;
      2'd2:    return 8;
      2'd3:    return 16;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/tx_ep_mem.sv
module tx_ep_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tx_ep_ptrs.sv
module tx_ep_ptrs #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          commit_i,
  input  logic          rewind_i,
  input  logic          flush_i,
  input  logic [1:0]    lim_i,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] count_o,
  output logic          avail_o,
  output logic          full_o,
  output logic          warn_o
);
  // wp: write, bp: committed base (held for retry), sp: speculative read
  logic [CW-1:0] wp_q, bp_q, sp_q, sp_nxt;

  always_comb begin
    if (rewind_i)   sp_nxt = bp_q;
    else if (pop_i) sp_nxt = sp_q + CW'(1);
    else            sp_nxt = sp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      bp_q <= '0;
      sp_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0;
      bp_q <= '0;
      sp_q <= '0;
    end else begin
      if (push_i)   wp_q <= wp_q + CW'(1);
      if (commit_i) bp_q <= sp_nxt;
      sp_q <= sp_nxt;
    end
  end

  assign count_o = wp_q - bp_q;
  assign full_o  = (count_o == CW'(DEPTH));
  assign avail_o = (sp_q != wp_q);
  assign waddr_o = wp_q[AW-1:0];
  assign raddr_o = sp_q[AW-1:0];
  assign warn_o  = (lim_i != 2'd0) && (int'(count_o) <= tx_ep_pkg::warn_thr(lim_i));
endmodule

// File: rtl/tx_ep_seq.sv
module tx_ep_seq
  import tx_ep_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tok_i,
  input  logic          ep_en_i,
  input  logic          stall_i,
  input  logic          arm_i,
  input  logic          toggle_i,
  input  logic          flush_i,
  input  logic          ack_i,
  input  logic          err_i,
  input  logic          stat_rd_i,
  input  logic          ovf_set_i,
  input  logic [CW-1:0] count_i,
  output resp_e         resp_o,
  output logic          pid_o,
  output logic [CW-1:0] len_o,
  output logic          sending_o,
  output logic          commit_o,
  output logic          rewind_o,
  output logic          tx_en_o,
  output logic          done_o,
  output logic          nak_ev_o,
  output logic          ovf_o
);
  resp_e         resp_q;
  logic          pid_q, send_q, en_q, done_q, nak_q, ovf_q;
  logic [CW-1:0] len_q;

  assign commit_o = send_q && ack_i && !flush_i;
  assign rewind_o = send_q && err_i && !ack_i && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q <= RESP_NONE;
      pid_q  <= 1'b0;
      len_q  <= '0;
      send_q <= 1'b0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
      nak_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      resp_q <= RESP_NONE;
      // clears first so that events in the same cycle win
      if (stat_rd_i) begin
        done_q <= 1'b0;
        nak_q  <= 1'b0;
        ovf_q  <= 1'b0;
      end
      if (ovf_set_i) ovf_q <= 1'b1;
      if (arm_i) begin
        en_q  <= 1'b1;
        pid_q <= toggle_i;
      end
      if (flush_i) begin
        send_q <= 1'b0;
      end else if (send_q) begin
        if (ack_i) begin
          send_q <= 1'b0;
          en_q   <= 1'b0;
          done_q <= 1'b1;
        end else if (err_i) begin
          send_q <= 1'b0;
        end
      end else if (tok_i && ep_en_i) begin
        if (stall_i) begin
          resp_q <= RESP_STALL;
          en_q   <= 1'b0;
          done_q <= 1'b1;
        end else if (en_q) begin
          resp_q <= RESP_DATA;
          send_q <= 1'b1;
          len_q  <= count_i;
        end else begin
          resp_q <= RESP_NAK;
          nak_q  <= 1'b1;
        end
      end
    end
  end

  assign resp_o    = resp_q;
  assign pid_o     = pid_q;
  assign len_o     = len_q;
  assign sending_o = send_q;
  assign tx_en_o   = en_q;
  assign done_o    = done_q;
  assign nak_ev_o  = nak_q;
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/tx_ep_fifo_ctrl.sv
module tx_ep_fifo_ctrl
  import tx_ep_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          arm_i,
  input  logic          toggle_i,
  input  logic          flush_i,
  input  logic          stall_i,
  input  logic [1:0]    warn_lim_i,
  input  logic          ep_en_i,
  input  logic          in_tok_i,
  input  logic          rd_req_i,
  input  logic          ack_i,
  input  logic          err_i,
  input  logic          stat_rd_i,
  output logic [1:0]    resp_o,
  output logic          pid_o,
  output logic [CW-1:0] len_o,
  output logic [DW-1:0] rd_data_o,
  output logic          tx_en_o,
  output logic          done_o,
  output logic          nak_ev_o,
  output logic          ovf_o,
  output logic [CW-1:0] free_cnt_o,
  output logic          warn_o
);
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] count;
  logic          avail, full, push, pop, ovf_set;
  logic          sending, commit, rewind;
  resp_e         resp;

  assign push    = wr_valid_i && !full && !flush_i;
  assign ovf_set = wr_valid_i && full && !flush_i;
  assign pop     = rd_req_i && sending && avail && !flush_i;

  tx_ep_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (push),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (rd_data_o)
  );

  tx_ep_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push),
    .pop_i    (pop),
    .commit_i (commit),
    .rewind_i (rewind),
    .flush_i  (flush_i),
    .lim_i    (warn_lim_i),
    .waddr_o  (waddr),
    .raddr_o  (raddr),
    .count_o  (count),
    .avail_o  (avail),
    .full_o   (full),
    .warn_o   (warn_o)
  );

  tx_ep_seq #(.CW(CW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tok_i     (in_tok_i),
    .ep_en_i   (ep_en_i),
    .stall_i   (stall_i),
    .arm_i     (arm_i),
    .toggle_i  (toggle_i),
    .flush_i   (flush_i),
    .ack_i     (ack_i),
    .err_i     (err_i),
    .stat_rd_i (stat_rd_i),
    .ovf_set_i (ovf_set),
    .count_i   (count),
    .resp_o    (resp),
    .pid_o     (pid_o),
    .len_o     (len_o),
    .sending_o (sending),
    .commit_o  (commit),
    .rewind_o  (rewind),
    .tx_en_o   (tx_en_o),
    .done_o    (done_o),
    .nak_ev_o  (nak_ev_o),
    .ovf_o     (ovf_o)
  );

  assign resp_o     = resp;
  assign free_cnt_o = CW'(DEPTH) - count;
endmodule

// File: rtl/tx_ep_fifo_ctrl_chk.sv
module tx_ep_fifo_ctrl_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_valid_i,
  input logic          arm_i,
  input logic          flush_i,
  input logic          stall_i,
  input logic [1:0]    warn_lim_i,
  input logic          ep_en_i,
  input logic          in_tok_i,
  input logic          ack_i,
  input logic          err_i,
  input logic          sending,
  input logic [1:0]    resp_o,
  input logic          tx_en_o,
  input logic          done_o,
  input logic          nak_ev_o,
  input logic          ovf_o,
  input logic [CW-1:0] free_cnt_o,
  input logic          warn_o
);
  p_free_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cnt_o <= CW'(DEPTH));

  p_full_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cnt_o == '0 && wr_valid_i && !flush_i && !(sending && ack_i)
    |=> free_cnt_o == '0 && ovf_o);

  p_tok_answer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_tok_i && ep_en_i && !sending && !flush_i |=> resp_o != 2'd0);

  p_nak_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_o == 2'd2 |-> nak_ev_o);

  p_stall_prio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_tok_i && ep_en_i && stall_i && !sending && !flush_i
    |=> resp_o == 2'd3 && !tx_en_o && done_o);

  p_ack_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sending && ack_i && !flush_i |=> done_o && !tx_en_o);

  p_err_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sending && err_i && !ack_i && !flush_i && !wr_valid_i && !arm_i
    |=> tx_en_o == $past(tx_en_o) && free_cnt_o == $past(free_cnt_o));

  p_flush_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> free_cnt_o == CW'(DEPTH) && !sending);

  p_warn_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_lim_i == 2'd0 |-> !warn_o);

  p_no_ep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_tok_i && !ep_en_i && !sending |=> resp_o == 2'd0);
endmodule

bind tx_ep_fifo_ctrl tx_ep_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_i),
  .arm_i      (arm_i),
  .flush_i    (flush_i),
  .stall_i    (stall_i),
  .warn_lim_i (warn_lim_i),
  .ep_en_i    (ep_en_i),
  .in_tok_i   (in_tok_i),
  .ack_i      (ack_i),
  .err_i      (err_i),
  .sending    (sending),
  .resp_o     (resp_o),
  .tx_en_o    (tx_en_o),
  .done_o     (done_o),
  .nak_ev_o   (nak_ev_o),
  .ovf_o      (ovf_o),
  .free_cnt_o (free_cnt_o),
  .warn_o     (warn_o)
);

// File: tb/tx_ep_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module tx_ep_fifo_ctrl_tb;
  localparam int DEPTH = 64;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_valid_i = 0, arm_i = 0, toggle_i = 0, flush_i = 0, stall_i = 0;
  logic ep_en_i = 0, in_tok_i = 0, rd_req_i = 0, ack_i = 0, err_i = 0, stat_rd_i = 0;
  logic [DW-1:0] wr_data_i = '0;
  logic [1:0]    warn_lim_i = '0;
  logic [1:0]    resp_o;
  logic          pid_o, tx_en_o, done_o, nak_ev_o, ovf_o, warn_o;
  logic [CW-1:0] len_o, free_cnt_o;
  logic [DW-1:0] rd_data_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  tx_ep_fifo_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_dut (.*);

  // {n_bytes[15:8], lim[5:4], exp_warn[0]}
  localparam int NV = 11;
  localparam logic [15:0] VEC [NV] = '{
    16'h0000, 16'h0411, 16'h0510, 16'h0821, 16'h0920, 16'h1031,
    16'h1130, 16'h0300, 16'h0031, 16'h1010, 16'h4030
  };

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [DW-1:0] d);
    wr_valid_i = 1; wr_data_i = d; tick(); wr_valid_i = 0;
  endtask

  task automatic pulse_flush();
    flush_i = 1; tick(); flush_i = 0;
  endtask

  task automatic arm(input logic t);
    arm_i = 1; toggle_i = t; tick(); arm_i = 0;
  endtask

  task automatic token();
    in_tok_i = 1; tick(); in_tok_i = 0;
  endtask

  task automatic stat_rd();
    stat_rd_i = 1; tick(); stat_rd_i = 0;
  endtask

  task automatic read_pkt(input int n, input int base, input string req);
    for (int i = 0; i < n; i++) begin
      chk(req, rd_data_o, base + i);
      rd_req_i = 1; tick(); rd_req_i = 0;
    end
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // reset state
    chk("R1 reset free", free_cnt_o, DEPTH);
    chk("R1 reset tx_en", tx_en_o, 0);
    chk("R1 reset resp", resp_o, 0);
    chk("R1 reset done", done_o, 0);

    // warning thresholds and free count
    for (int v = 0; v < NV; v++) begin
      pulse_flush();
      for (int b = 0; b < int'(VEC[v][15:8]); b++) wr_byte(DW'(b));
      warn_lim_i = VEC[v][5:4];
      #1;
      chk("R9 warn", warn_o, VEC[v][0]);
      chk("R1 free", free_cnt_o, DEPTH - int'(VEC[v][15:8]));
    end
    warn_lim_i = 0;
    pulse_flush();

    // NAK when not armed
    ep_en_i = 1;
    token();
    chk("R4 nak resp", resp_o, 2);
    chk("R4 nak event", nak_ev_o, 1);
    tick();
    chk("R4 resp one cycle", resp_o, 0);
    stat_rd();
    chk("R10 nak clear", nak_ev_o, 0);

    // endpoint disabled
    ep_en_i = 0;
    token();
    chk("R11 no resp", resp_o, 0);
    chk("R11 no nak", nak_ev_o, 0);
    ep_en_i = 1;

    // data packet, error, retry, ack
    for (int i = 0; i < 5; i++) wr_byte(DW'(8'hA0 + i));
    arm(1'b1);
    chk("R3 armed", tx_en_o, 1);
    token();
    chk("R3 data resp", resp_o, 1);
    chk("R3 pid", pid_o, 1);
    chk("R3 len", len_o, 5);
    read_pkt(5, 'hA0, "R3 byte");
    err_i = 1; tick(); err_i = 0;
    chk("R7 data kept", free_cnt_o, DEPTH - 5);
    chk("R7 still armed", tx_en_o, 1);
    token();
    chk("R7 retry resp", resp_o, 1);
    chk("R7 retry len", len_o, 5);
    read_pkt(5, 'hA0, "R7 retry byte");
    ack_i = 1; tick(); ack_i = 0;
    chk("R6 released", free_cnt_o, DEPTH);
    chk("R6 disarmed", tx_en_o, 0);
    chk("R6 done", done_o, 1);
    stat_rd();
    chk("R10 done clear", done_o, 0);

    // STALL wins over armed data
    for (int i = 0; i < 3; i++) wr_byte(DW'(i));
    arm(1'b0);
    stall_i = 1;
    token();
    chk("R5 stall resp", resp_o, 3);
    chk("R5 disarmed", tx_en_o, 0);
    chk("R5 done", done_o, 1);
    chk("R5 data kept", free_cnt_o, DEPTH - 3);
    stall_i = 0;
    stat_rd();

    // overflow
    pulse_flush();
    for (int i = 0; i < DEPTH; i++) wr_byte(DW'(i));
    chk("R2 full", free_cnt_o, 0);
    chk("R2 no ovf yet", ovf_o, 0);
    wr_byte(8'hFF);
    chk("R2 dropped", free_cnt_o, 0);
    chk("R2 ovf flag", ovf_o, 1);
    stat_rd();
    chk("R10 ovf clear", ovf_o, 0);

    // DATA0 packet, flush mid-packet
    arm(1'b0);
    token();
    chk("R3 data0 resp", resp_o, 1);
    chk("R3 pid0", pid_o, 0);
    chk("R3 len full", len_o, DEPTH);
    read_pkt(2, 0, "R3 byte full");
    pulse_flush();
    chk("R8 flushed", free_cnt_o, DEPTH);
    token();
    chk("R8 send aborted, new resp", resp_o, 1);
    chk("R8 empty len", len_o, 0);
    ack_i = 1; tick(); ack_i = 0;
    chk("R8 free after ack", free_cnt_o, DEPTH);

    tick();
    finish_run();
  end
endmodule